// File: doc/BRIEF.md
# I2C Controller Interrupt Status Flags

This block keeps the interrupt and status flags of an I2C controller. A separate bit-level engine shifts the bits on the bus and reports what it has done through single-cycle strobes and level signals. This block turns those reports into six sticky flags. Each flag has its own rule for being set and cleared. The block packs the flags into one 8-bit status word and raises a single level interrupt request.

The block compares each received address byte with the programmed own address. It supports 7-bit and 10-bit addressing, so in 10-bit mode a match needs two bytes. It recognises the two reserved single-byte codes: the general call (0x00) and the START byte (0x01). It records the transfer direction from the first address byte of every transaction, in master mode as well as slave mode. It also watches the engine's SDA drive/sample strobe to detect lost arbitration.

Software talks to the block through a strobe interface. A read of the status register returns a snapshot one cycle later, and any flag cleared by that read drops on the same edge. Reads and writes of the data register only clear flags here; the data itself is held elsewhere.

Top module: `i2c_irq_status`

## Requirements
- R1: After reset the status word is 0x80 (transmit-empty set, every other bit clear), the read-back register is 0x00 and the interrupt request is low. Bits 1 and 0 of the status word always read 0.
- R2: Bit 7 (transmit empty) clears when software writes the data register (`reg_wr` with `reg_sel`=1). It sets again on an `eng_tx_empty` strobe.
- R3: The transmit-empty flag does not drive the interrupt while `eng_rx_busy` is high. It also does not drive the interrupt while `eng_addr_busy` is high and bit 3 (direction) is 1. With `eng_addr_busy` high and direction 0, it does drive the interrupt.
- R4: Bit 6 (receive full) sets on an `eng_byte_done` strobe. It clears when software reads the data register (`reg_rd` with `reg_sel`=1).
- R5: In slave mode with 7-bit addressing, bit 5 (address match) sets when bits [7:1] of a first address byte equal `own_addr[6:0]`. It never sets in master mode. A status read (`reg_rd` with `reg_sel`=0) places the pre-read status word on `sts_rdata` in the next cycle and clears bit 5 on the same edge.
- R6: In slave mode with 10-bit addressing, bit 5 sets only after two bytes match. The first byte must equal 11110 followed by `own_addr[9:8]` and a direction bit. The second byte, strobed by `eng_addr2_done`, must equal `own_addr[7:0]`. A wrong first or second byte leaves bit 5 clear.
- R7: With `ctl_gc_en` set in slave mode, a first address byte of 0x00 or 0x01 sets bit 5 and bit 4 (special address). With `ctl_gc_en` clear, these bytes set neither bit. Bit 4 is re-evaluated at every slave first address byte and is not cleared by a status read.
- R8: Bit 3 (direction) takes bit 0 of every first address byte in both master and slave mode. It is therefore 0 for a general call and 1 for a START byte.
- R9: While `ctl_enable` is 0, bits 4 and 3 are cleared, the interrupt request is low, and no strobe or register access changes any flag.
- R10: In master mode, an `eng_sda_check` strobe with `eng_sda_drive`=1 and `eng_sda_seen`=0 sets bit 2 (arbitration lost). The same strobe has no effect in slave mode or when the sampled level matches. A status read clears bit 2.
- R11: A set event in the same cycle as the access that would clear the same flag wins, and the flag stays set.
- R12: While enabled, `irq` is the OR of receive full, the masked transmit empty, address match and arbitration lost. It stays high until every contributing flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_enable | input | 1 | Controller enable |
| ctl_slave | input | 1 | 1 = slave mode, 0 = master mode |
| ctl_addr10 | input | 1 | 1 = 10-bit slave addressing |
| ctl_gc_en | input | 1 | Enable recognition of general call / START byte |
| own_addr | input | 10 | Own slave address (7-bit mode uses [6:0]) |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = status register, 1 = data register |
| sts_rdata | output | 8 | Status snapshot returned one cycle after a status read |
| eng_addr1_done | input | 1 | Strobe: first address byte complete, byte on eng_rx_byte |
| eng_addr2_done | input | 1 | Strobe: second (10-bit) address byte complete |
| eng_byte_done | input | 1 | Strobe: data byte received |
| eng_rx_byte | input | 8 | Byte that accompanies the address strobes |
| eng_tx_empty | input | 1 | Strobe: transmit data register has been emptied |
| eng_rx_busy | input | 1 | Level: shifting in a received data byte |
| eng_addr_busy | input | 1 | Level: shifting an address byte |
| eng_sda_check | input | 1 | Strobe: engine compares driven and sampled SDA |
| eng_sda_drive | input | 1 | Level the engine drove on SDA |
| eng_sda_seen | input | 1 | Level sampled on SDA |
| status_word | output | 8 | Live status word |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest situations to reach are a set event and its own clearing access arriving in the same clock cycle, and the masking of transmit-empty by an address shift whose direction was fixed by an earlier byte. The directed tasks reach the first by driving an address-match strobe together with a status read, and a byte-received strobe together with a data read, on one edge. They then compare the returned snapshot and the live word. They reach the second by sending a master-mode address byte with bit 0 set before raising the address-shift level. The 10-bit cases run the first byte right, then the second byte wrong, and the first byte wrong, to show that the pending half-match is neither kept nor borrowed.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 10;

    // status word bit positions
    localparam int BIT_TXE   = 7;
    localparam int BIT_RXF   = 6;
    localparam int BIT_MATCH = 5;
    localparam int BIT_GC    = 4;
    localparam int BIT_DIR   = 3;
    localparam int BIT_ARB   = 2;

    // leading pattern of the first byte of a 10-bit address
    localparam logic [4:0] TENBIT_PREFIX = 5'b11110;

    typedef struct packed {
        logic txe;
        logic rxf;
        logic match;
        logic gc;
        logic dir;
        logic arb;
    } flags_t;

    localparam flags_t FLAGS_RESET = '{txe: 1'b1, rxf: 1'b0, match: 1'b0,
                                       gc: 1'b0, dir: 1'b0, arb: 1'b0};

endpackage

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_stat_pkg::*;
#(
    parameter int BW = BYTE_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          slave,
    input  logic          addr10,
    input  logic          gc_en,
    input  logic [AW-1:0] own_addr,
    input  logic          first_done,
    input  logic          second_done,
    input  logic [BW-1:0] rx_byte,
    output logic          hit,
    output logic          special_seen,
    output logic          dir_bit
);

    localparam int HI_W = AW - BW;

    typedef struct packed {
        logic hi_pend;
    } am_state_t;

    am_state_t am_d, am_q;

    logic is_special;
    logic own7_hit;
    logic hi_ok;
    logic own10_hit;
    logic gc_hit;

    always_comb begin
        is_special = (rx_byte[BW-1:1] == '0);
        hi_ok      = (rx_byte[BW-1:BW-5] == TENBIT_PREFIX) &&
                     (rx_byte[HI_W:1] == own_addr[AW-1:BW]);
        own7_hit   = first_done && !addr10 &&
                     (rx_byte[BW-1:1] == own_addr[BW-2:0]);
        own10_hit  = second_done && addr10 && am_q.hi_pend &&
                     (rx_byte == own_addr[BW-1:0]);
        gc_hit     = first_done && gc_en && is_special;

        hit          = enable && slave && (own7_hit || own10_hit || gc_hit);
        special_seen = gc_en && is_special;
        dir_bit      = rx_byte[0];

        am_d = am_q;
        if (!enable || !slave) begin
            am_d.hi_pend = 1'b0;
        end else if (first_done) begin
            am_d.hi_pend = addr10 && hi_ok;
        end else if (second_done) begin
            am_d.hi_pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            am_q <= '0;
        end else begin
            am_q <= am_d;
        end
    end

    // a second address byte never matches in 7-bit mode
    assert_no_second_byte_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (second_done && !first_done && !addr10) |-> !hit);

    // a single-byte match is impossible in master mode
    assert_no_master_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !slave |-> !hit);

endmodule

// File: rtl/i2c_flag_bank.sv
module i2c_flag_bank
    import i2c_stat_pkg::*;
#(
    parameter int BW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          slave,
    input  logic          tx_empty_set,
    input  logic          data_wr,
    input  logic          rxf_set,
    input  logic          data_rd,
    input  logic          match_set,
    input  logic          special_seen,
    input  logic          addr1_seen,
    input  logic          dir_bit,
    input  logic          arb_set,
    input  logic          sts_rd,
    input  logic          rx_busy,
    input  logic          addr_busy,
    output logic [BW-1:0] status_word,
    output logic          irq
);

    flags_t fl_d, fl_q;
    logic   txe_mask;

    always_comb begin
        fl_d = fl_q;
        if (enable) begin
            // clears first, sets after, so a same-cycle set wins
            if (data_wr) fl_d.txe = 1'b0;
            if (data_rd) fl_d.rxf = 1'b0;
            if (sts_rd) begin
                fl_d.match = 1'b0;
                fl_d.arb   = 1'b0;
            end
            if (tx_empty_set) fl_d.txe   = 1'b1;
            if (rxf_set)      fl_d.rxf   = 1'b1;
            if (match_set)    fl_d.match = 1'b1;
            if (arb_set)      fl_d.arb   = 1'b1;
            if (addr1_seen) begin
                fl_d.dir = dir_bit;
                if (slave) fl_d.gc = special_seen;
            end
        end else begin
            fl_d.gc  = 1'b0;
            fl_d.dir = 1'b0;
        end

        status_word            = '0;
        status_word[BIT_TXE]   = fl_q.txe;
        status_word[BIT_RXF]   = fl_q.rxf;
        status_word[BIT_MATCH] = fl_q.match;
        status_word[BIT_GC]    = fl_q.gc;
        status_word[BIT_DIR]   = fl_q.dir;
        status_word[BIT_ARB]   = fl_q.arb;

        txe_mask = rx_busy || (addr_busy && fl_q.dir);
        irq      = enable && (fl_q.rxf || (fl_q.txe && !txe_mask) ||
                              fl_q.match || fl_q.arb);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= FLAGS_RESET;
        end else begin
            fl_q <= fl_d;
        end
    end

    assert_match_read_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && sts_rd && !match_set) |=> !fl_q.match);

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && match_set) |=> fl_q.match);

    assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!fl_q.gc && !fl_q.dir));

    assert_txe_write_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && data_wr && !tx_empty_set) |=> !fl_q.txe);

    assert_rxf_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && rxf_set) |=> (irq || !enable));

    assert_arb_master_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        arb_set |-> !slave);

endmodule

// File: rtl/i2c_irq_status.sv
module i2c_irq_status
    import i2c_stat_pkg::*;
#(
    parameter int BW = BYTE_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_enable,
    input  logic          ctl_slave,
    input  logic          ctl_addr10,
    input  logic          ctl_gc_en,
    input  logic [AW-1:0] own_addr,
    input  logic          reg_rd,
    input  logic          reg_wr,
    input  logic          reg_sel,
    output logic [BW-1:0] sts_rdata,
    input  logic          eng_addr1_done,
    input  logic          eng_addr2_done,
    input  logic          eng_byte_done,
    input  logic [BW-1:0] eng_rx_byte,
    input  logic          eng_tx_empty,
    input  logic          eng_rx_busy,
    input  logic          eng_addr_busy,
    input  logic          eng_sda_check,
    input  logic          eng_sda_drive,
    input  logic          eng_sda_seen,
    output logic [BW-1:0] status_word,
    output logic          irq
);

    logic          sts_rd;
    logic          data_rd;
    logic          data_wr;
    logic          arb_set;
    logic          hit;
    logic          special_seen;
    logic          dir_bit;
    logic [BW-1:0] rdata_d, rdata_q;

    always_comb begin
        sts_rd  = reg_rd && !reg_sel;
        data_rd = reg_rd && reg_sel;
        data_wr = reg_wr && reg_sel;
        arb_set = ctl_enable && !ctl_slave && eng_sda_check &&
                  eng_sda_drive && !eng_sda_seen;
        rdata_d = sts_rd ? status_word : rdata_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign sts_rdata = rdata_q;

    i2c_addr_match #(.BW(BW), .AW(AW)) u_match (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (ctl_enable),
        .slave        (ctl_slave),
        .addr10       (ctl_addr10),
        .gc_en        (ctl_gc_en),
        .own_addr     (own_addr),
        .first_done   (eng_addr1_done),
        .second_done  (eng_addr2_done),
        .rx_byte      (eng_rx_byte),
        .hit          (hit),
        .special_seen (special_seen),
        .dir_bit      (dir_bit)
    );

    i2c_flag_bank #(.BW(BW)) u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (ctl_enable),
        .slave        (ctl_slave),
        .tx_empty_set (eng_tx_empty),
        .data_wr      (data_wr),
        .rxf_set      (eng_byte_done),
        .data_rd      (data_rd),
        .match_set    (hit),
        .special_seen (special_seen),
        .addr1_seen   (eng_addr1_done),
        .dir_bit      (dir_bit),
        .arb_set      (arb_set),
        .sts_rd       (sts_rd),
        .rx_busy      (eng_rx_busy),
        .addr_busy    (eng_addr_busy),
        .status_word  (status_word),
        .irq          (irq)
    );

    // status bits 1 and 0 are not owned here and always read 0
    assert_low_bits_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[1:0] == 2'b00);

endmodule

// File: tb/tb_i2c_irq_status.sv
module tb_i2c_irq_status;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_enable = 1'b0, ctl_slave = 1'b0, ctl_addr10 = 1'b0, ctl_gc_en = 1'b0;
    logic [9:0] own_addr = 10'h2A5;
    logic       reg_rd = 1'b0, reg_wr = 1'b0, reg_sel = 1'b0;
    logic [7:0] sts_rdata;
    logic       eng_addr1_done = 1'b0, eng_addr2_done = 1'b0, eng_byte_done = 1'b0;
    logic [7:0] eng_rx_byte = 8'h00;
    logic       eng_tx_empty = 1'b0, eng_rx_busy = 1'b0, eng_addr_busy = 1'b0;
    logic       eng_sda_check = 1'b0, eng_sda_drive = 1'b0, eng_sda_seen = 1'b0;
    logic [7:0] status_word;
    logic       irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    i2c_irq_status dut (
        .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .ctl_slave(ctl_slave),
        .ctl_addr10(ctl_addr10), .ctl_gc_en(ctl_gc_en), .own_addr(own_addr),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_sel(reg_sel), .sts_rdata(sts_rdata),
        .eng_addr1_done(eng_addr1_done), .eng_addr2_done(eng_addr2_done),
        .eng_byte_done(eng_byte_done), .eng_rx_byte(eng_rx_byte),
        .eng_tx_empty(eng_tx_empty), .eng_rx_busy(eng_rx_busy),
        .eng_addr_busy(eng_addr_busy), .eng_sda_check(eng_sda_check),
        .eng_sda_drive(eng_sda_drive), .eng_sda_seen(eng_sda_seen),
        .status_word(status_word), .irq(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // one clock edge, then drop every strobe
    task automatic tick();
        @(negedge clk);
        reg_rd = 0; reg_wr = 0; eng_addr1_done = 0; eng_addr2_done = 0;
        eng_byte_done = 0; eng_tx_empty = 0; eng_sda_check = 0;
    endtask

    task automatic addr1(input logic [7:0] b);
        eng_rx_byte = b; eng_addr1_done = 1; tick();
    endtask

    task automatic addr2(input logic [7:0] b);
        eng_rx_byte = b; eng_addr2_done = 1; tick();
    endtask

    task automatic sts_read();
        reg_sel = 0; reg_rd = 1; tick();
    endtask

    task automatic data_read();
        reg_sel = 1; reg_rd = 1; tick();
    endtask

    task automatic data_write();
        reg_sel = 1; reg_wr = 1; tick();
    endtask

    task automatic t_reset();
        chk("R1 reset status", status_word, 8'h80);
        chk("R1 reset rdata", sts_rdata, 8'h00);
        chk("R1 reset irq", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_tdre();
        ctl_enable = 1; tick();
        chk("R12 irq from txe", {7'b0, irq}, 8'h01);
        data_write();
        chk("R2 write clears txe", status_word, 8'h00);
        chk("R12 irq drops", {7'b0, irq}, 8'h00);
        eng_tx_empty = 1; tick();
        chk("R2 tx empty sets", status_word, 8'h80);
    endtask

    task automatic t_mask();
        eng_rx_busy = 1; #1;
        chk("R3 masked by rx busy", {7'b0, irq}, 8'h00);
        eng_rx_busy = 0; eng_addr_busy = 1; #1;
        chk("R3 addr busy dir0 unmasked", {7'b0, irq}, 8'h01);
        eng_addr_busy = 0;
        ctl_slave = 0; addr1(8'h4B);
        chk("R5 R8 master: dir set, no match", status_word, 8'h88);
        eng_addr_busy = 1; #1;
        chk("R3 addr busy dir1 masked", {7'b0, irq}, 8'h00);
        eng_addr_busy = 0;
        addr1(8'h4A);
        chk("R8 master dir back to 0", status_word, 8'h80);
    endtask

    task automatic t_rdrf();
        eng_byte_done = 1; tick();
        chk("R4 byte sets rxf", status_word, 8'hC0);
        data_read();
        chk("R4 data read clears rxf", status_word, 8'h80);
    endtask

    task automatic t_seven();
        ctl_slave = 1;
        addr1(8'h4A);
        chk("R5 own 7-bit match", status_word, 8'hA0);
        sts_read();
        chk("R5 snapshot before clear", sts_rdata, 8'hA0);
        chk("R5 read clears match", status_word, 8'h80);
        addr1(8'h4C);
        chk("R5 mismatch", status_word, 8'h80);
    endtask

    task automatic t_ten();
        ctl_addr10 = 1;
        addr1(8'hF4);
        chk("R6 first byte alone", status_word, 8'h80);
        addr2(8'hA5);
        chk("R6 both bytes match", status_word, 8'hA0);
        sts_read();
        addr1(8'hF4); addr2(8'hA6);
        chk("R6 wrong second byte", status_word, 8'h80);
        addr1(8'hF6); addr2(8'hA5);
        chk("R6 wrong first byte", status_word, 8'h80);
        ctl_addr10 = 0;
    endtask

    task automatic t_gc();
        ctl_gc_en = 0; addr1(8'h00);
        chk("R7 gc disabled", status_word, 8'h80);
        ctl_gc_en = 1; addr1(8'h00);
        chk("R7 R8 general call", status_word, 8'hB0);
        sts_read();
        chk("R7 gc survives status read", status_word, 8'h90);
        addr1(8'h01);
        chk("R7 R8 start byte", status_word, 8'hB8);
        sts_read();
        addr1(8'h4A);
        chk("R7 gc re-evaluated", status_word, 8'hA0);
        sts_read();
        addr1(8'h4B);
        chk("R8 slave read dir", status_word, 8'hA8);
        sts_read();
        chk("R8 after read", status_word, 8'h88);
    endtask

    task automatic t_disable();
        addr1(8'h01); sts_read();
        chk("R9 setup", status_word, 8'h98);
        ctl_enable = 0; tick();
        chk("R9 disable clears gc dir", status_word, 8'h80);
        eng_byte_done = 1; tick();
        data_write();
        chk("R9 events ignored", status_word, 8'h80);
        chk("R9 irq low", {7'b0, irq}, 8'h00);
        ctl_enable = 1; tick();
    endtask

    task automatic t_arb();
        ctl_slave = 0;
        eng_sda_check = 1; eng_sda_drive = 1; eng_sda_seen = 0; tick();
        chk("R10 arb lost", status_word, 8'h84);
        sts_read();
        chk("R10 read clears arb", status_word, 8'h80);
        eng_sda_check = 1; eng_sda_drive = 1; eng_sda_seen = 1; tick();
        chk("R10 level matched", status_word, 8'h80);
        ctl_slave = 1;
        eng_sda_check = 1; eng_sda_drive = 1; eng_sda_seen = 0; tick();
        chk("R10 slave ignores", status_word, 8'h80);
    endtask

    task automatic t_race();
        eng_rx_byte = 8'h4A; eng_addr1_done = 1; reg_sel = 0; reg_rd = 1; tick();
        chk("R11 snapshot old", sts_rdata, 8'h80);
        chk("R11 match wins", status_word, 8'hA0);
        eng_byte_done = 1; tick();
        eng_byte_done = 1; reg_sel = 1; reg_rd = 1; tick();
        chk("R11 rxf wins", status_word, 8'hE0);
    endtask

    task automatic t_irq_hold();
        data_write();
        chk("R12 setup", status_word, 8'h60);
        sts_read();
        chk("R12 held by rxf", {7'b0, irq}, 8'h01);
        data_read();
        chk("R12 all clear", {7'b0, irq}, 8'h00);
        chk("R12 final word", status_word, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        tick();
        t_reset();
        t_tdre();
        t_mask();
        t_rdrf();
        t_seven();
        t_ten();
        t_gc();
        t_disable();
        t_arb();
        t_race();
        t_irq_hold();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule